// File: doc/BRIEF.md
# Dual-Group Clock Divider with Phase Offset

This block takes one fast input clock and produces ten divided clocks in two groups of five. Each group picks its own division factor from a fixed menu through a 4-bit code. Group 1 can be delayed against group 0 by a whole number of phase steps. How many steps exist, and how long each one is, depends on group 1's factor. Each of the ten outputs has its own enable.

Software-style settings arrive as plain parallel inputs. When a code or the phase value changes, the block restarts both dividers from a common edge by itself. Group 0 restarts at once. Group 1 restarts after its phase lag has run out. An enable change never cuts a pulse short.

Top module: `dual_group_clkdiv`

## Requirements
- R1: Ratio codes 0..10 select division factors 1, 2, 4, 5, 8, 10, 16, 20, 32, 40, 80 in that order. A group with factor P repeats every P input cycles.
- R2: For every even factor, a group clock is high for P/2 input cycles and low for the rest. Factor 5 is high for 2 cycles and low for 3.
- R3: With factor 1, an enabled output follows the input clock: high while the input is high, low while it is low.
- R4: A code of 11 to 15 on a ratio input is ignored. The previous factor stays in force and no restart occurs.
- R5: When a ratio code is accepted as a change, or when the phase value changes, both groups restart. Group 0 is high in the first input cycle after that edge.
- R6: Group 1 starts D input cycles after group 0, where D = (phase mod N) * L. For a factor P that is a multiple of 5, N = P/5 and L = 5. For any other factor, N = P and L = 1.
- R7: Outputs clk_out[4:0] belong to group 0 and clk_out[9:5] to group 1. Output i is forced low while out_en[i] is 0.
- R8: A change of out_en[i] takes effect only in a cycle where the group clock is low, so no shortened high pulse is produced.
- R9: While reset is held, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio0_code | input | 4 | Division code for group 0 |
| ratio1_code | input | 4 | Division code for group 1 |
| phase_step | input | 8 | Phase lag of group 1 in steps |
| out_en | input | 10 | Per-output enables, bit i for clk_out[i] |
| clk_out | output | 10 | Divided clocks, group 0 in bits 4:0 |

## Verification
A table of ratio and phase pairs drives the bench. Every waveform is compared with a model over 170 input cycles. The pairs mix both groups sharing a factor, factor 5 against an even factor, and lags that come from multiples of five. They also include phase values at or above the step count, so that wrap-around, a zero lag and a 20-cycle lag are each told apart. A separate run feeds invalid codes part-way through and expects the waveform to carry on unbroken. Another run toggles two enables, one in each group, at times that fall inside a high phase, so any early cut-off or early start would show. The factor-1 path is sampled in both halves of the input clock.

// File: rtl/dgcd_pkg.sv
package dgcd_pkg;
  localparam int RW    = 7;   // enough for the largest factor
  localparam int PH_W  = 8;
  localparam int NCODE = 11;

  typedef logic [RW-1:0]   ratio_t;
  typedef logic [PH_W-1:0] ph_t;

  function automatic ratio_t ratio_of(input logic [3:0] idx);
    case (idx)
      4'd0:    return 7'd1;
      4'd1:    return 7'd2;
      4'd2:    return 7'd4;
      4'd3:    return 7'd5;
      4'd4:    return 7'd8;
      4'd5:    return 7'd10;
      4'd6:    return 7'd16;
      4'd7:    return 7'd20;
      4'd8:    return 7'd32;
      4'd9:    return 7'd40;
      4'd10:   return 7'd80;
      default: return 7'd1;
    endcase
  endfunction

  function automatic logic code_ok(input logic [3:0] c);
    return c < 4'(NCODE);
  endfunction

  // input cycles per phase step
  function automatic ratio_t step_len(input ratio_t p);
    return (p % 7'd5 == 7'd0) ? 7'd5 : 7'd1;
  endfunction

  function automatic ratio_t step_cnt(input ratio_t p);
    return p / step_len(p);
  endfunction

  function automatic ratio_t hi_len(input ratio_t p);
    return p >> 1;
  endfunction

  // start lag of group 1 in input cycles; always below p
  function automatic ratio_t lag_of(input ratio_t p, input ph_t ph);
    ph_t m;
    m = ph % ph_t'(step_cnt(p));
    return ratio_t'(m) * step_len(p);
  endfunction
endpackage

// File: rtl/dgcd_cfg.sv
module dgcd_cfg
  import dgcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] code0_i,
  input  logic [3:0] code1_i,
  input  ph_t        phase_i,
  output ratio_t     ratio0_q,
  output ratio_t     ratio1_q,
  output ratio_t     ratio0_nxt,
  output ratio_t     ratio1_nxt,
  output logic       sync_o,
  output logic       run1_nxt_o,
  output ratio_t     lag_q
);
  logic [3:0] idx0_q, idx1_q, idx0_n, idx1_n;
  ph_t        ph_q;
  ratio_t     lag_n;

  always_comb begin
    idx0_n     = code_ok(code0_i) ? code0_i : idx0_q;
    idx1_n     = code_ok(code1_i) ? code1_i : idx1_q;
    ratio0_nxt = ratio_of(idx0_n);
    ratio1_nxt = ratio_of(idx1_n);
    ratio0_q   = ratio_of(idx0_q);
    ratio1_q   = ratio_of(idx1_q);
    sync_o     = (idx0_n != idx0_q) || (idx1_n != idx1_q) || (phase_i != ph_q);
    if (sync_o)             lag_n = lag_of(ratio1_nxt, phase_i);
    else if (lag_q != '0)   lag_n = lag_q - 7'd1;
    else                    lag_n = '0;
    run1_nxt_o = (lag_n == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx0_q <= '0;
      idx1_q <= '0;
      ph_q   <= '0;
      lag_q  <= '0;
    end else begin
      idx0_q <= idx0_n;
      idx1_q <= idx1_n;
      ph_q   <= phase_i;
      lag_q  <= lag_n;
    end
  end

  a_r4_bad_code0_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !code_ok(code0_i) |=> idx0_q == $past(idx0_q));
  a_r4_bad_code1_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !code_ok(code1_i) |=> idx1_q == $past(idx1_q));
endmodule

// File: rtl/dgcd_grp.sv
module dgcd_grp
  import dgcd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_t ratio_i,
  input  logic   restart_i,
  input  logic   run_i,
  output logic   act_q,
  output logic   div_q,
  output logic   div_nxt
);
  ratio_t cnt_q, cnt_n;

  always_comb begin
    if (restart_i || !act_q || cnt_q == ratio_i - 7'd1) cnt_n = '0;
    else                                                 cnt_n = cnt_q + 7'd1;
    div_nxt = run_i && (cnt_n < hi_len(ratio_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      act_q <= run_i;
      div_q <= div_nxt;
    end
  end

  a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> cnt_q == '0);
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> cnt_q < $past(ratio_i));
endmodule

// File: rtl/dgcd_gate.sv
module dgcd_gate #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bypass_i,
  input  logic         act_i,
  input  logic         div_q_i,
  input  logic         div_nxt_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] out_o
);
  logic [N-1:0] en_q, en_lo;

  for (genvar g = 0; g < N; g++) begin : g_out
    // divided path: enable moves only when the clock stays low after the edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          en_q[g] <= 1'b0;
      else if (!div_nxt_i) en_q[g] <= en_i[g];
    end
    // factor-1 path: enable moves only while the input clock is low
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) en_lo[g] <= 1'b0;
      else        en_lo[g] <= en_i[g] & act_i;
    end
    assign out_o[g] = bypass_i ? (clk & en_lo[g]) : (div_q_i & en_q[g]);

    a_r8_en_in_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(en_q[g]) |-> !div_q_i);
  end
endmodule

// File: rtl/dual_group_clkdiv.sv
module dual_group_clkdiv
  import dgcd_pkg::*;
#(
  parameter int PER_GRP = 5
) (
  input  logic                 clk_in,
  input  logic                 rst_n,
  input  logic [3:0]           ratio0_code,
  input  logic [3:0]           ratio1_code,
  input  logic [PH_W-1:0]      phase_step,
  input  logic [2*PER_GRP-1:0] out_en,
  output logic [2*PER_GRP-1:0] clk_out
);
  localparam int NOUT = 2 * PER_GRP;

  ratio_t r0_q, r1_q, r0_n, r1_n, lag_q;
  logic   sync, run1_n;
  logic   act0, act1, div0_q, div1_q, div0_n, div1_n;

  dgcd_cfg u_cfg (
    .clk(clk_in), .rst_n(rst_n), .code0_i(ratio0_code), .code1_i(ratio1_code),
    .phase_i(phase_step), .ratio0_q(r0_q), .ratio1_q(r1_q),
    .ratio0_nxt(r0_n), .ratio1_nxt(r1_n), .sync_o(sync),
    .run1_nxt_o(run1_n), .lag_q(lag_q)
  );

  dgcd_grp u_grp0 (
    .clk(clk_in), .rst_n(rst_n), .ratio_i(r0_n), .restart_i(sync),
    .run_i(1'b1), .act_q(act0), .div_q(div0_q), .div_nxt(div0_n)
  );

  dgcd_grp u_grp1 (
    .clk(clk_in), .rst_n(rst_n), .ratio_i(r1_n), .restart_i(sync),
    .run_i(run1_n), .act_q(act1), .div_q(div1_q), .div_nxt(div1_n)
  );

  dgcd_gate #(.N(PER_GRP)) u_gate0 (
    .clk(clk_in), .rst_n(rst_n), .bypass_i(r0_q == 7'd1), .act_i(act0),
    .div_q_i(div0_q), .div_nxt_i(div0_n), .en_i(out_en[PER_GRP-1:0]),
    .out_o(clk_out[PER_GRP-1:0])
  );

  dgcd_gate #(.N(PER_GRP)) u_gate1 (
    .clk(clk_in), .rst_n(rst_n), .bypass_i(r1_q == 7'd1), .act_i(act1),
    .div_q_i(div1_q), .div_nxt_i(div1_n), .en_i(out_en[NOUT-1:PER_GRP]),
    .out_o(clk_out[NOUT-1:PER_GRP])
  );

  a_r6_lag_holds_g1: assert property (@(posedge clk_in) disable iff (!rst_n)
    (lag_q != '0) |-> !act1);
  a_r5_sync_starts_g0: assert property (@(posedge clk_in) disable iff (!rst_n)
    sync && (r0_n != 7'd1) |=> act0 && div0_q);
endmodule

// File: tb/dual_group_clkdiv_bench.sv
module dual_group_clkdiv_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] code0 = 4'd0, code1 = 4'd0;
  logic [7:0] phase = 8'd0;
  logic [9:0] out_en = 10'h3FF;
  logic [9:0] clk_out;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  dual_group_clkdiv u_dual_group_clkdiv (
    .clk_in(clk), .rst_n(rst_n), .ratio0_code(code0), .ratio1_code(code1),
    .phase_step(phase), .out_en(out_en), .clk_out(clk_out)
  );

  typedef struct packed {
    logic [3:0] c0; logic [3:0] c1; logic [7:0] ph;
    logic [7:0] p0; logic [7:0] p1; logic [7:0] d;
  } vec_t;

  // codes, phase, expected factors and group-1 lag (R1, R2, R5, R6)
  localparam vec_t VEC [8] = '{
    '{4'd1, 4'd1, 8'd0,  8'd2,  8'd2,  8'd0},
    '{4'd2, 4'd3, 8'd0,  8'd4,  8'd5,  8'd0},
    '{4'd3, 4'd5, 8'd1,  8'd5,  8'd10, 8'd5},
    '{4'd4, 4'd4, 8'd3,  8'd8,  8'd8,  8'd3},
    '{4'd6, 4'd2, 8'd6,  8'd16, 8'd4,  8'd2},
    '{4'd5, 4'd7, 8'd7,  8'd10, 8'd20, 8'd15},
    '{4'd8, 4'd10, 8'd20, 8'd32, 8'd80, 8'd20},
    '{4'd9, 4'd9, 8'd8,  8'd40, 8'd40, 8'd0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic run_cfg(input logic [3:0] c0, input logic [3:0] c1,
                         input logic [7:0] ph, input int p0, input int p1,
                         input int d, input int bad_at, input int tog_a,
                         input int tog_b, input logic [9:0] mask,
                         input string req);
    logic [9:0] en_in, en_eff, exp_v, bad_act, bad_exp;
    bit g0, g1, gi, bad;
    int bad_k;
    bad = 0; bad_k = -1; bad_act = '0; bad_exp = '0;
    @(negedge clk); #1;
    code0 = c0; code1 = c1; phase = ph;
    en_in = out_en; en_eff = out_en;
    for (int k = 0; k < 170; k++) begin
      @(negedge clk); #1;
      g0 = (k % p0) < (p0 / 2);
      g1 = (k < d) ? 1'b0 : (((k - d) % p1) < (p1 / 2));
      for (int i = 0; i < 10; i++) begin
        gi = (i < 5) ? g0 : g1;
        if (!gi) en_eff[i] = en_in[i];
        exp_v[i] = gi & en_eff[i];
      end
      if (clk_out !== exp_v && !bad) begin
        bad = 1; bad_k = k; bad_act = clk_out; bad_exp = exp_v;
      end
      if (k == bad_at - 1) begin code0 = 4'd13; code1 = 4'd15; end
      if (k == tog_a - 1 || k == tog_b - 1) begin
        out_en = out_en ^ mask; en_in = out_en;
      end
    end
    check(!bad, req, $sformatf("waveform p0=%0d p1=%0d d=%0d at sample %0d",
          p0, p1, d, bad_k), bad_act, bad_exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(clk_out == 10'h0, "R9", "outputs during reset (clock high)", clk_out, 10'h0);
    @(negedge clk); #1;
    rst_n = 1'b1;

    // R1 R2 R5 R6: table walk
    for (int r = 0; r < 8; r++)
      run_cfg(VEC[r].c0, VEC[r].c1, VEC[r].ph, int'(VEC[r].p0), int'(VEC[r].p1),
              int'(VEC[r].d), -1, -1, -1, 10'h0, "R1/R2/R5/R6");

    // R4: invalid codes mid-run leave the waveform untouched
    run_cfg(4'd2, 4'd4, 8'd2, 4, 8, 2, 30, -1, -1, 10'h0, "R4");

    // R7 R8: enable toggles inside high phases, factors 5 and 4, lag 3
    run_cfg(4'd3, 4'd2, 8'd3, 5, 4, 3, -1, 20, 47, 10'b01_0000_0010, "R7/R8");

    // R3 R7: factor 1 on both groups, output 5 disabled
    @(negedge clk); #1;
    code0 = 4'd0; code1 = 4'd0; phase = 8'd5; out_en = 10'b11110_11111;
    repeat (4) @(negedge clk);
    @(posedge clk); #2;
    check(clk_out == 10'b11110_11111, "R3", "factor 1, input high", clk_out, 10'b11110_11111);
    @(negedge clk); #2;
    check(clk_out == 10'h0, "R3", "factor 1, input low", clk_out, 10'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule